// File: doc/BRIEF.md
# Miss-Driven Cache Bank Partitioner

This block decides, cycle by cycle, how the banks of a shared first-level cache are divided between an instruction virtual cache and a data virtual cache. It watches two miss strobes, one from the instruction fetch path and one from the load/store path. It folds them into a single shared up/down saturating selector. When the selector is pushed to the top of its range, the data side gives one bank to the instruction side. When it is pushed to the bottom, the transfer goes the other way. After any move the selector returns to the middle of its range.

The block outputs three things. The first is an ownership mask with one bit per bank. The second is the number of banks held by each side. The third is an estimated hit latency for each virtual cache, which grows with the number of banks that cache holds. A single-cycle move pulse carries the index of the moved bank and its new owner. A neighbouring block uses this pulse to write back or invalidate the lines of that bank. The cache arrays, the tag lookup and the line eviction are not part of this block.

Top module: `bank_partitioner`

## Requirements
- R1: At reset, bit b of `instr_own` is 1 (instruction-owned) for b < BANKS/2 and 0 (data-owned) otherwise. For BANKS=8 the mask is 8'h0F. Each side holds 4 banks, `move_valid` is 0, and the selector stands at BANKS.
- R2: A cycle with only `ifetch_miss` high raises the selector by one, and it saturates at 2*BANKS-1. A cycle with only `dload_miss` high lowers it by one, and it saturates at 0. The selector is evaluated right after each update.
- R3: A cycle with both strobes high, or with neither high, leaves the selector unchanged and never produces a move.
- R4: If an update leaves the selector at 2*BANKS-1 while data holds more than one bank, the highest-indexed data bank becomes instruction-owned and the selector returns to BANKS.
- R5: If an update leaves the selector at 0 while instructions hold more than one bank, the highest-indexed instruction bank becomes data-owned and the selector returns to BANKS.
- R6: A side holding exactly one bank never gives it up. In that case the selector stays saturated, and each side always holds at least one bank.
- R7: A move is visible one clock edge after the strobe that caused it. In that cycle `move_valid` is 1 for exactly one cycle, `move_bank` gives the bank index, and `move_to_instr` is 1 for a move to instructions and 0 for a move to data. The mask changes only in cycles where `move_valid` is 1.
- R8: `instr_banks` equals the number of ones in `instr_own`, and `instr_banks + data_banks` equals BANKS. Both counts update in the same cycle as the mask.
- R9: Each latency output is a 2-bit cycle count. It is 1 for 1–2 banks, 2 for 3–5 banks and 3 for 6 or more banks.
- R10: At most one bank changes owner per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ifetch_miss | input | 1 | Instruction-side miss strobe |
| dload_miss | input | 1 | Data-side miss strobe |
| instr_own | output | BANKS | Per-bank owner, 1 = instruction |
| instr_banks | output | $clog2(BANKS+1) | Banks held by instructions |
| data_banks | output | $clog2(BANKS+1) | Banks held by data |
| instr_lat | output | 2 | Estimated instruction hit latency |
| data_lat | output | 2 | Estimated data hit latency |
| move_valid | output | 1 | One-cycle bank move pulse |
| move_bank | output | $clog2(BANKS) | Index of the moved bank |
| move_to_instr | output | 1 | New owner of the moved bank |

## Verification
The bench counts exact strobe runs so that the move lands on the precise cycle the selector reaches an end. A design that moves one update early, or that skips the return to mid-range, shifts every later move. It drains the instruction side down to one bank and keeps pushing. A design without the floor would hand away the last bank or wrap the selector. It also holds both strobes high for long stretches, where a design that lets one strobe win would drift toward a move. Long biased random runs check that the highest-indexed donor bank is picked and that the latency bands switch at 2/3 and 5/6 banks.

// File: rtl/bpart_pkg.sv
package bpart_pkg;

    typedef enum logic {
        SIDE_DATA  = 1'b0,
        SIDE_INSTR = 1'b1
    } side_e;

    localparam int unsigned SIDES      = 2;
    localparam int unsigned LAT_FAST_N = 2;
    localparam int unsigned LAT_MID_N  = 5;

    function automatic logic [1:0] hit_latency(input int unsigned banks);
        if (banks <= LAT_FAST_N)     return 2'd1;
        else if (banks <= LAT_MID_N) return 2'd2;
        else                         return 2'd3;
    endfunction

endpackage

// File: rtl/bpart_selector.sv
module bpart_selector #(
    parameter int unsigned BANKS = 8,
    parameter int unsigned CW    = $clog2(2 * BANKS),
    parameter int unsigned CNTW  = $clog2(BANKS + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ifetch_miss,
    input  logic            dload_miss,
    input  logic [CNTW-1:0] instr_cnt,
    input  logic [CNTW-1:0] data_cnt,
    output logic            grant_to_instr,
    output logic            grant_to_data
);
    localparam logic [CW-1:0] SEL_MAX = CW'(2 * BANKS - 1);
    localparam logic [CW-1:0] SEL_MID = CW'(BANKS);

    logic [CW-1:0] sel_q;
    logic [CW-1:0] sel_step;
    logic [CW-1:0] sel_d;
    logic          up;
    logic          down;

    always_comb begin
        up   = ifetch_miss && !dload_miss;
        down = dload_miss && !ifetch_miss;
        sel_step = sel_q;
        if (up && sel_q != SEL_MAX)
            sel_step = sel_q + CW'(1);
        else if (down && sel_q != '0)
            sel_step = sel_q - CW'(1);
        grant_to_instr = up && (sel_step == SEL_MAX) && (data_cnt > CNTW'(1));
        grant_to_data  = down && (sel_step == '0) && (instr_cnt > CNTW'(1));
        sel_d = (grant_to_instr || grant_to_data) ? SEL_MID : sel_step;
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= SEL_MID;
        else     sel_q <= sel_d;
    end
endmodule

// File: rtl/bpart_owner.sv
module bpart_owner #(
    parameter int unsigned BANKS = 8,
    parameter int unsigned BW    = $clog2(BANKS),
    parameter int unsigned CNTW  = $clog2(BANKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             grant_to_instr,
    input  logic             grant_to_data,
    output logic [BANKS-1:0] own_q,
    output logic [CNTW-1:0]  instr_cnt,
    output logic [CNTW-1:0]  data_cnt,
    output logic             mv_valid,
    output logic [BW-1:0]    mv_bank,
    output logic             mv_to_instr
);
    import bpart_pkg::*;

    localparam int unsigned    I_INIT    = BANKS / 2;
    localparam int unsigned    D_INIT    = BANKS - I_INIT;
    localparam logic [BANKS-1:0] MASK_INIT = {BANKS{1'b1}} >> D_INIT;

    logic [BW-1:0] top_data;
    logic [BW-1:0] top_instr;

    always_comb begin
        top_data  = '0;
        top_instr = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (own_q[b] == SIDE_DATA)  top_data  = BW'(b);
            if (own_q[b] == SIDE_INSTR) top_instr = BW'(b);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q       <= MASK_INIT;
            instr_cnt   <= CNTW'(I_INIT);
            data_cnt    <= CNTW'(D_INIT);
            mv_valid    <= 1'b0;
            mv_bank     <= '0;
            mv_to_instr <= 1'b0;
        end else begin
            mv_valid    <= grant_to_instr || grant_to_data;
            mv_to_instr <= grant_to_instr;
            mv_bank     <= '0;
            if (grant_to_instr) begin
                own_q[top_data] <= SIDE_INSTR;
                instr_cnt       <= instr_cnt + CNTW'(1);
                data_cnt        <= data_cnt - CNTW'(1);
                mv_bank         <= top_data;
            end else if (grant_to_data) begin
                own_q[top_instr] <= SIDE_DATA;
                instr_cnt        <= instr_cnt - CNTW'(1);
                data_cnt         <= data_cnt + CNTW'(1);
                mv_bank          <= top_instr;
            end
        end
    end
endmodule

// File: rtl/bpart_latency.sv
module bpart_latency #(
    parameter int unsigned CNTW = 4
) (
    input  logic [CNTW-1:0] banks,
    output logic [1:0]      lat
);
    import bpart_pkg::*;

    always_comb lat = hit_latency(32'(banks));
endmodule

// File: rtl/bank_partitioner.sv
module bank_partitioner #(
    parameter int unsigned BANKS = 8,
    parameter int unsigned BW    = $clog2(BANKS),
    parameter int unsigned CNTW  = $clog2(BANKS + 1),
    parameter int unsigned CW    = $clog2(2 * BANKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ifetch_miss,
    input  logic             dload_miss,
    output logic [BANKS-1:0] instr_own,
    output logic [CNTW-1:0]  instr_banks,
    output logic [CNTW-1:0]  data_banks,
    output logic [1:0]       instr_lat,
    output logic [1:0]       data_lat,
    output logic             move_valid,
    output logic [BW-1:0]    move_bank,
    output logic             move_to_instr
);
    import bpart_pkg::*;

    logic            g_instr;
    logic            g_data;
    logic [CNTW-1:0] side_cnt [SIDES];
    logic [1:0]      side_lat [SIDES];

    bpart_selector #(.BANKS(BANKS), .CW(CW), .CNTW(CNTW)) u_sel (
        .clk            (clk),
        .rst            (rst),
        .ifetch_miss    (ifetch_miss),
        .dload_miss     (dload_miss),
        .instr_cnt      (instr_banks),
        .data_cnt       (data_banks),
        .grant_to_instr (g_instr),
        .grant_to_data  (g_data)
    );

    bpart_owner #(.BANKS(BANKS), .BW(BW), .CNTW(CNTW)) u_own (
        .clk            (clk),
        .rst            (rst),
        .grant_to_instr (g_instr),
        .grant_to_data  (g_data),
        .own_q          (instr_own),
        .instr_cnt      (instr_banks),
        .data_cnt       (data_banks),
        .mv_valid       (move_valid),
        .mv_bank        (move_bank),
        .mv_to_instr    (move_to_instr)
    );

    assign side_cnt[SIDE_DATA]  = data_banks;
    assign side_cnt[SIDE_INSTR] = instr_banks;

    for (genvar s = 0; s < SIDES; s++) begin : g_lat
        bpart_latency #(.CNTW(CNTW)) u_lat (
            .banks (side_cnt[s]),
            .lat   (side_lat[s])
        );
    end

    assign instr_lat = side_lat[SIDE_INSTR];
    assign data_lat  = side_lat[SIDE_DATA];
endmodule

// File: rtl/bank_partitioner_chk.sv
module bank_partitioner_chk #(
    parameter int unsigned BANKS = 8,
    parameter int unsigned BW    = $clog2(BANKS),
    parameter int unsigned CNTW  = $clog2(BANKS + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             ifetch_miss,
    input logic             dload_miss,
    input logic [BANKS-1:0] instr_own,
    input logic [CNTW-1:0]  instr_banks,
    input logic [CNTW-1:0]  data_banks,
    input logic [1:0]       instr_lat,
    input logic [1:0]       data_lat,
    input logic             move_valid,
    input logic [BW-1:0]    move_bank,
    input logic             move_to_instr
);
    AST_SUM_BANKS: assert property (@(posedge clk) disable iff (rst) 32'(instr_banks) + 32'(data_banks) == BANKS); // R8
    AST_MASK_POP: assert property (@(posedge clk) disable iff (rst) $countones(instr_own) == 32'(instr_banks)); // R8
    AST_FLOOR: assert property (@(posedge clk) disable iff (rst) instr_banks != '0 && data_banks != '0); // R6
    AST_ONE_FLIP: assert property (@(posedge clk) disable iff (rst) move_valid |-> $countones(instr_own ^ $past(instr_own)) == 1); // R10
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst) !move_valid |-> $stable(instr_own)); // R7
    AST_CANCEL: assert property (@(posedge clk) disable iff (rst) (ifetch_miss && dload_miss) |=> !move_valid); // R3
    AST_DIR_MATCH: assert property (@(posedge clk) disable iff (rst) move_valid |-> instr_own[move_bank] == move_to_instr); // R7
    AST_LAT_RANGE: assert property (@(posedge clk) disable iff (rst) instr_lat != 2'd0 && data_lat != 2'd0); // R9
endmodule

bind bank_partitioner bank_partitioner_chk #(.BANKS(BANKS), .BW(BW), .CNTW(CNTW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ifetch_miss   (ifetch_miss),
    .dload_miss    (dload_miss),
    .instr_own     (instr_own),
    .instr_banks   (instr_banks),
    .data_banks    (data_banks),
    .instr_lat     (instr_lat),
    .data_lat      (data_lat),
    .move_valid    (move_valid),
    .move_bank     (move_bank),
    .move_to_instr (move_to_instr)
);

// File: tb/bank_partitioner_bench.sv
module bank_partitioner_bench;
    localparam int NB   = 8;
    localparam int SMAX = 2 * NB - 1;
    localparam int SMID = NB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ifetch_miss = 1'b0;
    logic          dload_miss  = 1'b0;
    logic [NB-1:0] instr_own;
    logic [3:0]    instr_banks;
    logic [3:0]    data_banks;
    logic [1:0]    instr_lat;
    logic [1:0]    data_lat;
    logic          move_valid;
    logic [2:0]    move_bank;
    logic          move_to_instr;

    int compared = 0;
    int mismatched = 0;

    int          m_sel;
    logic [NB-1:0] m_own;
    int          m_ic;
    int          m_dc;
    logic        m_mv;
    int          m_mb;
    logic        m_mt;

    always #2.5 clk = ~clk;

    bank_partitioner #(.BANKS(NB)) u_bank_partitioner (
        .clk(clk), .rst(rst), .ifetch_miss(ifetch_miss), .dload_miss(dload_miss),
        .instr_own(instr_own), .instr_banks(instr_banks), .data_banks(data_banks),
        .instr_lat(instr_lat), .data_lat(data_lat), .move_valid(move_valid),
        .move_bank(move_bank), .move_to_instr(move_to_instr)
    );

    function automatic int exp_lat(input int n);
        if (n <= 2) return 1;
        if (n <= 5) return 2;
        return 3;
    endfunction

    task automatic check(input string tag, input string field, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, field, act, exp);
        end
    endtask

    task automatic model_reset();
        m_sel = SMID; m_own = 8'h0F; m_ic = 4; m_dc = 4;
        m_mv = 1'b0; m_mb = 0; m_mt = 1'b0;
    endtask

    task automatic model_step(input logic i, input logic d);
        int nxt;
        logic up, dn;
        up = i && !d; dn = d && !i;
        nxt = m_sel;
        if (up && m_sel != SMAX) nxt = m_sel + 1;
        else if (dn && m_sel != 0) nxt = m_sel - 1;
        m_mv = 1'b0; m_mb = 0; m_mt = 1'b0;
        if (up && nxt == SMAX && m_dc > 1) begin
            for (int b = 0; b < NB; b++) if (!m_own[b]) m_mb = b;
            m_own[m_mb] = 1'b1; m_ic++; m_dc--; m_mv = 1'b1; m_mt = 1'b1; m_sel = SMID;
        end else if (dn && nxt == 0 && m_ic > 1) begin
            for (int b = 0; b < NB; b++) if (m_own[b]) m_mb = b;
            m_own[m_mb] = 1'b0; m_ic--; m_dc++; m_mv = 1'b1; m_mt = 1'b0; m_sel = SMID;
        end else begin
            m_sel = nxt;
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "R4 R5 mask", int'(instr_own), int'(m_own));
        check(tag, "R8 instr count", int'(instr_banks), m_ic);
        check(tag, "R8 data count", int'(data_banks), m_dc);
        check(tag, "R9 instr latency", int'(instr_lat), exp_lat(m_ic));
        check(tag, "R9 data latency", int'(data_lat), exp_lat(m_dc));
        check(tag, "R7 pulse", int'(move_valid), int'(m_mv));
        if (m_mv) begin
            check(tag, "R7 bank", int'(move_bank), m_mb);
            check(tag, "R7 direction", int'(move_to_instr), int'(m_mt));
        end
    endtask

    task automatic step(input logic i, input logic d, input string tag);
        ifetch_miss = i; dload_miss = d;
        @(posedge clk);
        model_step(i, d);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        mismatched++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare_all("R1 reset");

        // R2 R4: seven instruction misses take the selector from 8 to 15
        for (int k = 0; k < 7; k++) step(1'b1, 1'b0, "R2 R4 climb");
        check("R4", "moved bank is 7", int'(m_mb), 7);

        // R3: simultaneous strobes cancel
        for (int k = 0; k < 20; k++) step(1'b1, 1'b1, "R3 cancel");
        for (int k = 0; k < 5; k++) step(1'b0, 1'b0, "R3 idle");

        // R5: eight data misses take the selector from 8 to 0
        for (int k = 0; k < 8; k++) step(1'b0, 1'b1, "R5 descend");

        // R6: drain instruction side to one bank, then keep pushing
        for (int k = 0; k < 80; k++) step(1'b0, 1'b1, "R6 floor");
        check("R6", "instr floor", int'(instr_banks), 1);
        for (int k = 0; k < 200; k++) step(1'b1, 1'b0, "R6 refill");
        check("R6", "data floor", int'(data_banks), 1);

        // R10: biased random blocks
        for (int blk = 0; blk < 40; blk++) begin
            int pi, pd;
            pi = int'($urandom % 100);
            pd = int'($urandom % 100);
            for (int k = 0; k < 150; k++)
                step(($urandom % 100) < pi, ($urandom % 100) < pd, "R10 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule